// File: doc/BRIEF.md
# Bus Master Domain Assignment

This block tags every bus transaction with a domain identifier and the privilege and secure attributes that downstream access checking will use. Each bus master owns a small private table of assignment entries. Software fills an entry by writing two words through a simple write port: one word carries a compare value and a don't-care mask for the transaction tag, and the other carries the domain, the attribute overrides and an optional lock.

A request arrives on a valid/ready stream with the originating master, its tag and its own privilege and secure attributes. The block compares the tag against every valid entry of that master's table. It returns the result on a second valid/ready stream, registered, in the cycle after the request is accepted. The lowest-numbered entry that hits supplies the domain and attributes. When no entry hits, the result is domain 0 with the request's own attributes. An entry can lock itself, and after that it ignores all writes until reset.

The result stage is one register deep. `req_ready` is high when that stage is empty or is being drained in the same cycle (`!rsp_valid || rsp_ready`). While `rsp_valid` is high and `rsp_ready` is low, the result holds its value unchanged, and no new request is accepted.

Top module: `bus_domain_assign`

## Requirements
- R1: After reset every entry is invalid and `rsp_valid` is 0. A lookup before any write therefore returns the no-hit default.
- R2: A write with `cfg_word`=0 stores the don't-care mask from `cfg_wdata[TAG_W-1:0]` and the compare value from `cfg_wdata[16 +: TAG_W]`.
- R3: A write with `cfg_word`=1 stores the domain from `cfg_wdata[DID_W-1:0]`, privilege from bit 8, secure from bit 9 and lock from bit 31. It always marks the entry valid, whatever the other bits are.
- R4: An entry hits when it is valid and `((tag ^ compare) & ~mask) == 0`. A mask bit of 1 means "don't care" for that tag bit.
- R5: When several entries of one master hit, the entry with the lowest index supplies the result.
- R6: When no entry hits, the result is domain 0 and the request's own `req_priv` and `req_sec`.
- R7: On a hit, the result carries the hitting entry's domain, privilege and secure values, not the request's.
- R8: Once an entry's lock is set, writes of either word to that entry have no effect until reset. Reset clears the lock.
- R9: A lookup uses only the table of `req_master`. A write changes only the entry selected by `cfg_master` and `cfg_index`.
- R10: A request accepted at a clock edge (`req_valid && req_ready`) appears with `rsp_valid`=1 right after that edge.
- R11: While `rsp_valid && !rsp_ready`, the result holds stable and `req_ready` is 0.
- R12: A write that takes effect at the same edge as an accepted request does not affect that request's result.
- R13: Fields of an entry that have not been written keep their reset values (mask 0, compare 0). An entry given only its attribute word therefore hits only tag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_master | input | clog2(NUM_MASTERS) | Master whose table is written |
| cfg_index | input | clog2(NUM_ENTRIES) | Entry index within that table |
| cfg_word | input | 1 | 0 = mask/compare word, 1 = attribute word |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_master | input | clog2(NUM_MASTERS) | Originating master |
| req_tag | input | TAG_W | Transaction tag compared against entries |
| req_priv | input | 1 | Request's own privilege attribute |
| req_sec | input | 1 | Request's own secure attribute |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_did | output | DID_W | Assigned domain |
| rsp_priv | output | 1 | Assigned privilege attribute |
| rsp_sec | output | 1 | Assigned secure attribute |

## Verification
The bench builds the block with its defaults: four masters, four entries each, an 8-bit tag and a 4-bit domain. With these values it can fill the top index of both the master and the entry ranges, and it can make overlapping entries so that priority among more than two hits is exercised. Every tag bit can also be placed under mask or compare. Random back-pressure on the result stream, together with a write in the same cycle as a request, covers the stall and ordering rules. A second reset in mid-run shows that locks are released.

// File: rtl/mda_pkg.sv
package mda_pkg;
  // Field positions inside the two configuration words.
  localparam int CMP_LSB  = 16;  // compare value in word 0
  localparam int PRIV_BIT = 8;   // word 1
  localparam int SEC_BIT  = 9;   // word 1
  localparam int LOCK_BIT = 31;  // word 1
  localparam int CFG_W    = 32;

  typedef enum logic {
    WORD_MASKCMP = 1'b0,
    WORD_ATTR    = 1'b1
  } cfg_word_e;
endpackage

// File: rtl/mda_entry.sv
module mda_entry
  import mda_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int DID_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  cfg_word_e        wr_word,
  input  logic [TAG_W-1:0] wr_mask,
  input  logic [TAG_W-1:0] wr_cmp,
  input  logic [DID_W-1:0] wr_did,
  input  logic             wr_priv,
  input  logic             wr_sec,
  input  logic             wr_lock,
  input  logic [TAG_W-1:0] tag,
  output logic             hit,
  output logic [DID_W-1:0] ent_did,
  output logic             ent_priv,
  output logic             ent_sec
);
  logic [TAG_W-1:0] mask_q, cmp_q;
  logic             valid_q, lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '0;
      cmp_q    <= '0;
      ent_did  <= '0;
      ent_priv <= 1'b1;
      ent_sec  <= 1'b1;
      valid_q  <= 1'b0;
      lock_q   <= 1'b0;
    end else if (wr_en && !lock_q) begin
      if (wr_word == WORD_MASKCMP) begin
        mask_q <= wr_mask;
        cmp_q  <= wr_cmp;
      end else begin
        ent_did  <= wr_did;
        ent_priv <= wr_priv;
        ent_sec  <= wr_sec;
        lock_q   <= wr_lock;
        valid_q  <= 1'b1;
      end
    end
  end

  assign hit = valid_q && (((tag ^ cmp_q) & ~mask_q) == '0);

  // R8: lock never falls outside reset
  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  // R8: a locked entry keeps all its fields
  p_locked_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(mask_q) && $stable(cmp_q) && $stable(ent_did)
                && $stable(ent_priv) && $stable(ent_sec)));
  // R3: attribute write on an unlocked entry leaves it valid
  p_attr_sets_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_word == WORD_ATTR && !lock_q) |=> valid_q);
endmodule

// File: rtl/mda_pick.sv
module mda_pick #(
  parameter int ENTRIES = 4,
  parameter int DID_W   = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ENTRIES-1:0]             hit_vec,
  input  logic [ENTRIES-1:0][DID_W-1:0]  did_vec,
  input  logic [ENTRIES-1:0]             priv_vec,
  input  logic [ENTRIES-1:0]             sec_vec,
  input  logic                           dflt_priv,
  input  logic                           dflt_sec,
  output logic [DID_W-1:0]               sel_did,
  output logic                           sel_priv,
  output logic                           sel_sec
);
  logic [ENTRIES-1:0] first_oh;

  always_comb begin
    logic found;
    found    = 1'b0;
    first_oh = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i] && !found) begin
        first_oh[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  always_comb begin
    sel_did  = '0;
    sel_priv = dflt_priv;
    sel_sec  = dflt_sec;
    for (int i = 0; i < ENTRIES; i++) begin
      if (first_oh[i]) begin
        sel_did  = did_vec[i];
        sel_priv = priv_vec[i];
        sel_sec  = sec_vec[i];
      end
    end
  end

  // R5: no hit below the chosen entry, and the chosen entry did hit
  p_lowest_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (first_oh != '0) |-> (((hit_vec & (first_oh - 1'b1)) == '0)
                          && ((first_oh & hit_vec) == first_oh)));
  // R4: any hit selects exactly one entry
  p_hit_selects_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec != '0) |-> $onehot(first_oh));
endmodule

// File: rtl/mda_rsp_stage.sv
module mda_rsp_stage #(
  parameter int DID_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DID_W-1:0] in_did,
  input  logic             in_priv,
  input  logic             in_sec,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DID_W-1:0] out_did,
  output logic             out_priv,
  output logic             out_sec
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_did   <= '0;
      out_priv  <= 1'b0;
      out_sec   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_did  <= in_did;
        out_priv <= in_priv;
        out_sec  <= in_sec;
      end
    end
  end

  // R11: a stalled result holds still
  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_did)
                                   && $stable(out_priv) && $stable(out_sec)));
  // R10: an accepted request yields a result on the next cycle
  p_accept_to_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/bus_domain_assign.sv
module bus_domain_assign
  import mda_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int NUM_ENTRIES = 4,
  parameter int TAG_W       = 8,
  parameter int DID_W       = 4,
  localparam int MW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1,
  localparam int EW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [MW-1:0]    cfg_master,
  input  logic [EW-1:0]    cfg_index,
  input  logic             cfg_word,
  input  logic [31:0]      cfg_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [MW-1:0]    req_master,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             req_priv,
  input  logic             req_sec,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [DID_W-1:0] rsp_did,
  output logic             rsp_priv,
  output logic             rsp_sec
);
  wire unused_cfg = &{1'b0, cfg_wdata};

  cfg_word_e wr_word;
  assign wr_word = cfg_word_e'(cfg_word);

  logic [NUM_MASTERS-1:0][DID_W-1:0] m_did;
  logic [NUM_MASTERS-1:0]            m_priv;
  logic [NUM_MASTERS-1:0]            m_sec;

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_master
    logic [NUM_ENTRIES-1:0]            hits;
    logic [NUM_ENTRIES-1:0][DID_W-1:0] dids;
    logic [NUM_ENTRIES-1:0]            privs;
    logic [NUM_ENTRIES-1:0]            secs;

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
      logic sel;
      assign sel = cfg_we && (cfg_master == MW'(m)) && (cfg_index == EW'(e));
      mda_entry #(.TAG_W(TAG_W), .DID_W(DID_W)) entry_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (sel),
        .wr_word  (wr_word),
        .wr_mask  (cfg_wdata[TAG_W-1:0]),
        .wr_cmp   (cfg_wdata[CMP_LSB +: TAG_W]),
        .wr_did   (cfg_wdata[DID_W-1:0]),
        .wr_priv  (cfg_wdata[PRIV_BIT]),
        .wr_sec   (cfg_wdata[SEC_BIT]),
        .wr_lock  (cfg_wdata[LOCK_BIT]),
        .tag      (req_tag),
        .hit      (hits[e]),
        .ent_did  (dids[e]),
        .ent_priv (privs[e]),
        .ent_sec  (secs[e])
      );
    end

    mda_pick #(.ENTRIES(NUM_ENTRIES), .DID_W(DID_W)) pick_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit_vec   (hits),
      .did_vec   (dids),
      .priv_vec  (privs),
      .sec_vec   (secs),
      .dflt_priv (req_priv),
      .dflt_sec  (req_sec),
      .sel_did   (m_did[m]),
      .sel_priv  (m_priv[m]),
      .sel_sec   (m_sec[m])
    );
  end

  logic [DID_W-1:0] look_did;
  logic             look_priv, look_sec;

  always_comb begin
    look_did  = '0;
    look_priv = req_priv;
    look_sec  = req_sec;
    for (int m = 0; m < NUM_MASTERS; m++) begin
      if (req_master == MW'(m)) begin
        look_did  = m_did[m];
        look_priv = m_priv[m];
        look_sec  = m_sec[m];
      end
    end
  end

  mda_rsp_stage #(.DID_W(DID_W)) stage_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_did    (look_did),
    .in_priv   (look_priv),
    .in_sec    (look_sec),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_did   (rsp_did),
    .out_priv  (rsp_priv),
    .out_sec   (rsp_sec)
  );

  // R11: back-pressure blocks new requests at the port
  p_stall_blocks_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

// File: tb/bus_domain_assign_tb_top.sv
module bus_domain_assign_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 4;
  localparam int NE = 4;
  localparam int TW = 8;
  localparam int DW = 4;
  localparam int MW = 2;
  localparam int EW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [MW-1:0] cfg_master = '0;
  logic [EW-1:0] cfg_index = '0;
  logic cfg_word = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [MW-1:0] req_master = '0;
  logic [TW-1:0] req_tag = '0;
  logic req_priv = 1'b0;
  logic req_sec = 1'b0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [DW-1:0] rsp_did;
  logic rsp_priv, rsp_sec;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_domain_assign #(.NUM_MASTERS(NM), .NUM_ENTRIES(NE), .TAG_W(TW), .DID_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_master(cfg_master),
    .cfg_index(cfg_index), .cfg_word(cfg_word), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_master(req_master),
    .req_tag(req_tag), .req_priv(req_priv), .req_sec(req_sec),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_did(rsp_did),
    .rsp_priv(rsp_priv), .rsp_sec(rsp_sec)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit bp_on = 1'b0;

  // reference table built from the requirements
  logic [TW-1:0] t_mask [NM][NE];
  logic [TW-1:0] t_cmp  [NM][NE];
  logic [DW-1:0] t_did  [NM][NE];
  logic          t_priv [NM][NE];
  logic          t_sec  [NM][NE];
  logic          t_val  [NM][NE];
  logic          t_lock [NM][NE];

  logic [DW+1:0] exp_q[$];
  string         rq_q[$];

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int m = 0; m < NM; m++)
      for (int e = 0; e < NE; e++) begin
        t_mask[m][e] = '0; t_cmp[m][e] = '0; t_did[m][e] = '0;
        t_priv[m][e] = 1'b1; t_sec[m][e] = 1'b1;
        t_val[m][e] = 1'b0; t_lock[m][e] = 1'b0;
      end
  endfunction

  function automatic void model_wr(int m, int e, bit w, logic [31:0] d);
    if (t_lock[m][e]) return;
    if (!w) begin
      t_mask[m][e] = d[TW-1:0];
      t_cmp[m][e]  = d[16 +: TW];
    end else begin
      t_did[m][e]  = d[DW-1:0];
      t_priv[m][e] = d[8];
      t_sec[m][e]  = d[9];
      t_lock[m][e] = d[31];
      t_val[m][e]  = 1'b1;
    end
  endfunction

  function automatic logic [DW+1:0] expect_of(int m, logic [TW-1:0] tag, logic p, logic s);
    for (int e = 0; e < NE; e++)
      if (t_val[m][e] && (((tag ^ t_cmp[m][e]) & ~t_mask[m][e]) == '0))
        return {t_did[m][e], t_priv[m][e], t_sec[m][e]};
    return {DW'(0), p, s};
  endfunction

  task automatic cfg_wr(int m, int e, bit w, logic [31:0] d);
    @(posedge clk); #2;
    req_valid = 1'b0;
    cfg_we = 1'b1; cfg_master = MW'(m); cfg_index = EW'(e);
    cfg_word = w; cfg_wdata = d;
    @(posedge clk); #2;
    cfg_we = 1'b0;
    model_wr(m, e, w, d);
  endtask

  function automatic logic [31:0] w0(logic [TW-1:0] mask, logic [TW-1:0] cmp);
    logic [31:0] d;
    d = '0; d[TW-1:0] = mask; d[16 +: TW] = cmp;
    return d;
  endfunction

  function automatic logic [31:0] w1(int did, bit p, bit s, bit lk);
    logic [31:0] d;
    d = '0; d[DW-1:0] = DW'(did); d[8] = p; d[9] = s; d[31] = lk;
    return d;
  endfunction

  // leaves req_valid high; the next task either replaces or drops it
  task automatic send(int m, logic [TW-1:0] tag, bit p, bit s, string rq);
    logic [DW+1:0] ex;
    @(posedge clk); #2;
    req_valid = 1'b1; req_master = MW'(m); req_tag = tag;
    req_priv = p; req_sec = s;
    ex = expect_of(m, tag, p, s);
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    exp_q.push_back(ex);
    rq_q.push_back(rq);
  endtask

  task automatic idle(int n);
    @(posedge clk); #2;
    req_valid = 1'b0;
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic drain();
    int guard = 0;
    req_valid = 1'b0;
    while (exp_q.size() != 0 && guard < 1000) begin
      @(posedge clk); guard++;
    end
    #2;
    chk(exp_q.size() == 0, "R10", "results outstanding", exp_q.size(), 0);
  endtask

  // result back-pressure
  initial begin
    forever begin
      @(posedge clk); #2;
      rsp_ready = bp_on ? 1'($urandom % 2) : 1'b1;
    end
  end

  // monitor / scoreboard
  bit prev_acc = 1'b0, prev_stall = 1'b0;
  logic [DW+1:0] held;
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        prev_acc = 1'b0; prev_stall = 1'b0;
      end else begin
        if (prev_acc)
          chk(rsp_valid == 1'b1, "R10", "rsp_valid after accept", int'(rsp_valid), 1);
        if (prev_stall)
          chk(rsp_valid && ({rsp_did, rsp_priv, rsp_sec} == held), "R11",
              "stalled result changed", int'({rsp_valid, rsp_did, rsp_priv, rsp_sec}),
              int'({1'b1, held}));
        if (prev_stall || (rsp_valid && !rsp_ready))
          chk(req_ready == 1'b0 || rsp_ready, "R11", "req_ready during stall",
              int'(req_ready), 0);
        if (rsp_valid && rsp_ready) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R10", "unexpected result", int'({rsp_did, rsp_priv, rsp_sec}), 0);
          end else begin
            logic [DW+1:0] ex;
            string rq;
            ex = exp_q.pop_front();
            rq = rq_q.pop_front();
            chk({rsp_did, rsp_priv, rsp_sec} == ex, rq, "result {did,priv,sec}",
                int'({rsp_did, rsp_priv, rsp_sec}), int'(ex));
          end
        end
        prev_acc   = req_valid && req_ready;
        prev_stall = rsp_valid && !rsp_ready;
        held       = {rsp_did, rsp_priv, rsp_sec};
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);

    // R1/R6: empty table gives the default with request attributes
    send(0, 8'h5A, 1'b0, 1'b1, "R1");
    send(3, 8'h00, 1'b1, 1'b0, "R6");
    idle(2);

    // R2/R4/R7: masked match on master 0 entry 2
    cfg_wr(0, 2, 1'b0, w0(8'h0F, 8'h30));
    cfg_wr(0, 2, 1'b1, w1(5, 1'b0, 1'b0, 1'b0));
    send(0, 8'h37, 1'b1, 1'b1, "R4");
    send(0, 8'h3F, 1'b1, 1'b1, "R7");
    send(0, 8'h47, 1'b1, 1'b0, "R6");
    send(0, 8'hB0, 1'b0, 1'b1, "R2");

    // R5: lower entry 1 overlaps entry 2
    cfg_wr(0, 1, 1'b0, w0(8'h03, 8'h34));
    cfg_wr(0, 1, 1'b1, w1(3, 1'b1, 1'b0, 1'b0));
    send(0, 8'h37, 1'b0, 1'b1, "R5");
    send(0, 8'h38, 1'b0, 1'b1, "R5");
    // highest entry overlapped by all
    cfg_wr(0, 3, 1'b0, w0(8'hFF, 8'h00));
    cfg_wr(0, 3, 1'b1, w1(15, 1'b0, 1'b1, 1'b0));
    send(0, 8'h35, 1'b0, 1'b0, "R5");
    send(0, 8'hC1, 1'b1, 1'b0, "R5");

    // R9: other masters unaffected
    send(1, 8'h37, 1'b0, 1'b0, "R9");
    send(3, 8'hC1, 1'b1, 1'b1, "R9");

    // R13: only the attribute word written
    cfg_wr(1, 0, 1'b1, w1(7, 1'b1, 1'b1, 1'b0));
    send(1, 8'h00, 1'b0, 1'b0, "R13");
    send(1, 8'h01, 1'b0, 1'b0, "R13");
    // R3: valid set regardless of other data bits
    cfg_wr(1, 3, 1'b1, 32'h0000_0302 | 32'h7000_0000);
    send(1, 8'h00, 1'b0, 1'b0, "R3");

    // R8: lock master 2 entry 3, later writes ignored
    cfg_wr(2, 3, 1'b0, w0(8'h00, 8'h11));
    cfg_wr(2, 3, 1'b1, w1(9, 1'b1, 1'b0, 1'b1));
    cfg_wr(2, 3, 1'b1, w1(2, 1'b0, 1'b1, 1'b0));
    cfg_wr(2, 3, 1'b0, w0(8'h00, 8'h22));
    send(2, 8'h11, 1'b0, 1'b1, "R8");
    send(2, 8'h22, 1'b0, 1'b1, "R8");
    idle(1);
    drain();

    // R12: write at the same edge as an accepted request
    @(posedge clk); #2;
    req_valid = 1'b1; req_master = 2'd3; req_tag = 8'h44; req_priv = 1'b1; req_sec = 1'b1;
    cfg_we = 1'b1; cfg_master = 2'd3; cfg_index = 2'd0; cfg_word = 1'b1;
    cfg_wdata = w1(6, 1'b0, 1'b0, 1'b0);
    exp_q.push_back(expect_of(3, 8'h44, 1'b1, 1'b1)); rq_q.push_back("R12");
    @(negedge clk);
    chk(req_ready == 1'b1, "R12", "req_ready for same-cycle case", int'(req_ready), 1);
    model_wr(3, 0, 1'b1, w1(6, 1'b0, 1'b0, 1'b0));
    @(posedge clk); #2;
    cfg_we = 1'b0;
    req_tag = 8'h00;
    exp_q.push_back(expect_of(3, 8'h00, 1'b1, 1'b1)); rq_q.push_back("R12");
    @(negedge clk);
    idle(1);
    drain();

    // R10/R11 with random back-pressure and random traffic
    bp_on = 1'b1;
    for (int k = 0; k < 40; k++)
      cfg_wr($urandom % NM, $urandom % NE, 1'($urandom % 2),
             $urandom & 32'h00FF_03FF);
    for (int k = 0; k < 400; k++)
      send($urandom % NM, TW'($urandom), 1'($urandom % 2), 1'($urandom % 2), "R11");
    idle(1);
    drain();
    bp_on = 1'b0;

    // R8: reset releases the lock
    @(posedge clk); #2 rst_n = 1'b0;
    model_reset();
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    send(2, 8'h11, 1'b1, 1'b0, "R1");
    cfg_wr(2, 3, 1'b1, w1(2, 1'b0, 1'b1, 1'b0));
    send(2, 8'h00, 1'b1, 1'b0, "R8");
    idle(1);
    drain();
    idle(2);
    finish_run();
  end
endmodule